// File: doc/BRIEF.md
# Transmitter-Side Basis Sifting Engine

This block sits on the transmitting side of a quantum key link and turns the receiver's detection reports into sifted-key material. Each report names a location (frame number and slot within the frame) and the basis the receiver measured in. The engine looks up the 4-bit symbol that was stored for that location when the pulse was sent. It compares the stored basis with the reported one. When they agree, it routes the result according to the pulse's intensity class.

Reports enter on a valid/ready stream. The engine handles one report at a time. It holds `in_ready` low from acceptance until it has either discarded the report or handed its result downstream. A result is offered on a second valid/ready stream. It stays on that stream, unchanged, until the consumer takes it, and results leave in the same order as their reports arrived.

The symbol store is outside the block and is reached through a request/response port with a fixed latency. Four free-running counters tally basis mismatches and matches of each class.

Top module: `sift_engine`

## Requirements
- R1: `in_ready` is high only when no report is in progress. A report is accepted on a cycle where `in_valid` and `in_ready` are both high. That same cycle raises `mem_req` with `mem_addr` = {`in_frame`, `in_slot`}. `in_ready` is low on the following cycle.
- R2: Bits [1:0] of the stored symbol select the polarization: 0 = H, 1 = V, 2 = P, 3 = N. Bit 1 is the basis (0 for H/V, 1 for P/N) and bit 0 is the key bit. A report matches when `in_basis` equals bit 1.
- R3: A mismatching report produces no output and increments `cnt_mismatch`.
- R4: Bits [3:2] give the class: 0 = signal, 1 = decoy, 2 = vacuum, 3 = unused. Class 3 is treated as vacuum. A matching vacuum report is never output and increments `cnt_vacuum`.
- R5: A matching decoy report is output with `out_kind` = 2 and increments `cnt_decoy`.
- R6: Matching signal reports increment `cnt_signal`. Counting from reset, the 10th, 20th, 30th, … of them are output with `out_kind` = 1 (error sample). All others are output with `out_kind` = 0 (key).
- R7: An output entry carries the report's frame, slot and key bit. It stays stable while `out_valid` is high and `out_ready` is low. Entries leave in report order.
- R8: With `out_ready` held high, a report is finished and `in_ready` is high again within 20 cycles of its acceptance.
- R9: After reset, `in_ready` is high, `out_valid` is low, all counters are zero and the sample phase starts over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Detection report offered |
| in_ready | output | 1 | Engine can take a report |
| in_frame | input | FRAME_W | Report frame number |
| in_slot | input | SLOT_W | Report slot within frame |
| in_basis | input | 1 | Receiver's measured basis |
| mem_req | output | 1 | Symbol read request |
| mem_addr | output | FRAME_W+SLOT_W | Symbol address {frame, slot} |
| mem_rvalid | input | 1 | Symbol read data valid |
| mem_rdata | input | 4 | Stored symbol {class, polarization} |
| out_valid | output | 1 | Sifted entry offered |
| out_ready | input | 1 | Consumer takes entry |
| out_frame | output | FRAME_W | Entry frame number |
| out_slot | output | SLOT_W | Entry slot |
| out_bit | output | 1 | Key bit |
| out_kind | output | 2 | 0 key, 1 error sample, 2 decoy |
| cnt_signal | output | CNT_W | Signal-class matches |
| cnt_decoy | output | CNT_W | Decoy-class matches |
| cnt_vacuum | output | CNT_W | Vacuum/unused-class matches |
| cnt_mismatch | output | CNT_W | Basis mismatches |

## Verification
The hardest situation to reach from the ports is a sampling boundary that falls while the output is stalled and is mixed in with discarded reports. Decoy, vacuum and mismatching reports all leave the sample phase untouched, so an error here would shift every later sample tag. The bench first walks all sixteen symbol codes with both bases. It then sends about fifteen hundred random reports against a store filled in the 6:1:1 class ratio, while `out_ready` is withheld at random. A bench-side reference tracks the sample phase, so each tag is checked across long stretches with many signal matches.

// File: rtl/sift_pkg.sv
package sift_pkg;

  typedef enum logic [1:0] {
    CLS_SIGNAL = 2'd0,
    CLS_DECOY  = 2'd1,
    CLS_VACUUM = 2'd2,
    CLS_SPARE  = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    KIND_KEY    = 2'd0,
    KIND_SAMPLE = 2'd1,
    KIND_DECOY  = 2'd2
  } kind_e;

  typedef struct packed {
    logic match;
    logic key_bit;
    cls_e cls;
  } verdict_t;

endpackage

// File: rtl/sift_decode.sv
module sift_decode
  import sift_pkg::*;
(
  input  logic [3:0] word,
  input  logic       basis,
  output verdict_t   verdict
);
  always_comb begin
    verdict.match   = (word[1] == basis);
    verdict.key_bit = word[0];
    verdict.cls     = cls_e'(word[3:2]);
  end
endmodule

// File: rtl/sift_sampler.sv
module sift_sampler #(
  parameter int PERIOD = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic is_sample
);
  localparam int PH_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);

  logic [PH_W-1:0] phase;

  assign is_sample = (phase == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)
      phase <= '0;
    else if (adv)
      phase <= is_sample ? '0 : phase + 1'b1;
  end

  // R6
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= LAST);
endmodule

// File: rtl/sift_counters.sv
module sift_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       inc,
  output logic [3:0][CNT_W-1:0] cnt
);
  for (genvar g = 0; g < 4; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt[g] <= '0;
      else if (inc[g])
        cnt[g] <= cnt[g] + 1'b1;
    end
  end

  // R3
  one_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(inc));
endmodule

// File: rtl/sift_engine.sv
module sift_engine
  import sift_pkg::*;
#(
  parameter int FRAME_W       = 8,
  parameter int SLOT_W        = 10,
  parameter int CNT_W         = 16,
  parameter int SAMPLE_PERIOD = 10,
  parameter int MAX_LOOKUP    = 20
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [FRAME_W-1:0]        in_frame,
  input  logic [SLOT_W-1:0]         in_slot,
  input  logic                      in_basis,
  output logic                      mem_req,
  output logic [FRAME_W+SLOT_W-1:0] mem_addr,
  input  logic                      mem_rvalid,
  input  logic [3:0]                mem_rdata,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [FRAME_W-1:0]        out_frame,
  output logic [SLOT_W-1:0]         out_slot,
  output logic                      out_bit,
  output logic [1:0]                out_kind,
  output logic [CNT_W-1:0]          cnt_signal,
  output logic [CNT_W-1:0]          cnt_decoy,
  output logic [CNT_W-1:0]          cnt_vacuum,
  output logic [CNT_W-1:0]          cnt_mismatch
);
  localparam int WC_W = $clog2(MAX_LOOKUP + 1);
  localparam logic [WC_W-1:0] WC_MAX = WC_W'(MAX_LOOKUP);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_OUT} st_e;

  st_e               state;
  logic [FRAME_W-1:0] hold_frame;
  logic [SLOT_W-1:0]  hold_slot;
  logic               hold_basis;
  logic               bit_q;
  kind_e              kind_q;
  logic [WC_W-1:0]    wait_cyc;

  verdict_t verdict;
  logic     decide, emit, is_sample;
  logic     inc_sig, inc_dec, inc_vac, inc_mis;
  logic [3:0][CNT_W-1:0] cnt_all;
  kind_e    kind_d;

  sift_decode u_decode (
    .word    (mem_rdata),
    .basis   (hold_basis),
    .verdict (verdict)
  );

  assign decide  = (state == ST_WAIT) && mem_rvalid;
  assign inc_mis = decide && !verdict.match;
  assign inc_sig = decide && verdict.match && (verdict.cls == CLS_SIGNAL);
  assign inc_dec = decide && verdict.match && (verdict.cls == CLS_DECOY);
  assign inc_vac = decide && verdict.match && verdict.cls[1];
  assign emit    = inc_sig || inc_dec;

  sift_sampler #(.PERIOD(SAMPLE_PERIOD)) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (inc_sig),
    .is_sample (is_sample)
  );

  sift_counters #(.CNT_W(CNT_W)) u_counters (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   ({inc_mis, inc_vac, inc_dec, inc_sig}),
    .cnt   (cnt_all)
  );

  assign cnt_signal   = cnt_all[0];
  assign cnt_decoy    = cnt_all[1];
  assign cnt_vacuum   = cnt_all[2];
  assign cnt_mismatch = cnt_all[3];

  always_comb begin
    if (verdict.cls == CLS_DECOY) kind_d = KIND_DECOY;
    else if (is_sample)           kind_d = KIND_SAMPLE;
    else                          kind_d = KIND_KEY;
  end

  assign in_ready  = (state == ST_IDLE);
  assign mem_req   = in_valid && in_ready;
  assign mem_addr  = {in_frame, in_slot};
  assign out_valid = (state == ST_OUT);
  assign out_frame = hold_frame;
  assign out_slot  = hold_slot;
  assign out_bit   = bit_q;
  assign out_kind  = kind_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      hold_frame <= '0;
      hold_slot  <= '0;
      hold_basis <= 1'b0;
      bit_q      <= 1'b0;
      kind_q     <= KIND_KEY;
      wait_cyc   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (in_valid) begin
          hold_frame <= in_frame;
          hold_slot  <= in_slot;
          hold_basis <= in_basis;
          wait_cyc   <= '0;
          state      <= ST_WAIT;
        end
        ST_WAIT: begin
          if (wait_cyc != WC_MAX) wait_cyc <= wait_cyc + 1'b1;
          if (mem_rvalid) begin
            if (emit) begin
              bit_q  <= verdict.key_bit;
              kind_q <= kind_d;
              state  <= ST_OUT;
            end else begin
              state  <= ST_IDLE;
            end
          end
        end
        ST_OUT: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_frame) &&
      $stable(out_slot) && $stable(out_bit) && $stable(out_kind)));

  // R8
  lookup_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> (wait_cyc < WC_MAX));

  // R1
  rsp_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> (state == ST_WAIT));
endmodule

// File: tb/sift_engine_tb_top.sv
module sift_engine_tb_top;
  localparam int FW = 4;
  localparam int SW = 6;
  localparam int AW = FW + SW;
  localparam int DEPTH = 1 << AW;
  localparam int CW = 16;
  localparam int LAT = 3;
  localparam int NRAND = 1500;
  localparam int QN = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          in_valid = 1'b0, in_ready;
  logic [FW-1:0] in_frame = '0;
  logic [SW-1:0] in_slot = '0;
  logic          in_basis = 1'b0;
  logic          mem_req, mem_rvalid;
  logic [AW-1:0] mem_addr;
  logic [3:0]    mem_rdata;
  logic          out_valid, out_ready = 1'b0, out_bit;
  logic [FW-1:0] out_frame;
  logic [SW-1:0] out_slot;
  logic [1:0]    out_kind;
  logic [CW-1:0] cnt_signal, cnt_decoy, cnt_vacuum, cnt_mismatch;

  sift_engine #(.FRAME_W(FW), .SLOT_W(SW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_frame(in_frame), .in_slot(in_slot), .in_basis(in_basis),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .out_valid(out_valid), .out_ready(out_ready),
    .out_frame(out_frame), .out_slot(out_slot), .out_bit(out_bit),
    .out_kind(out_kind), .cnt_signal(cnt_signal), .cnt_decoy(cnt_decoy),
    .cnt_vacuum(cnt_vacuum), .cnt_mismatch(cnt_mismatch));

  // behavioural symbol store, fixed latency
  logic [3:0]    store [0:DEPTH-1];
  logic [LAT-1:0] pv = '0;
  logic [AW-1:0] pa [0:LAT-1];
  always @(posedge clk) begin
    pv[0] <= mem_req;
    pa[0] <= mem_addr;
    for (int i = 1; i < LAT; i++) begin
      pv[i] <= pv[i-1];
      pa[i] <= pa[i-1];
    end
  end
  assign mem_rvalid = pv[LAT-1];
  assign mem_rdata  = store[pa[LAT-1]];

  int compared = 0, mismatched = 0;
  int e_sig = 0, e_dec = 0, e_vac = 0, e_mis = 0;
  logic [AW-1:0] q_loc [0:QN-1];
  logic          q_bit [0:QN-1];
  logic [1:0]    q_kind [0:QN-1];
  int q_wr = 0, q_rd = 0;
  int ready_mode = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference model: requirements R2..R6
  task automatic predict(input logic [AW-1:0] a, input logic b);
    logic [3:0] w;
    w = store[a];
    if (w[1] != b) e_mis++;
    else if (w[3]) e_vac++;
    else if (w[2]) begin
      e_dec++;
      q_loc[q_wr] = a; q_bit[q_wr] = w[0]; q_kind[q_wr] = 2'd2; q_wr++;
    end else begin
      e_sig++;
      q_loc[q_wr] = a; q_bit[q_wr] = w[0];
      q_kind[q_wr] = (e_sig % 10 == 0) ? 2'd1 : 2'd0; q_wr++;
    end
  endtask

  task automatic send(input logic [AW-1:0] a, input logic b, input bit timed);
    int cyc;
    @(negedge clk);
    in_valid = 1'b1; {in_frame, in_slot} = a; in_basis = b;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    predict(a, b);
    if (timed) begin
      // R1: request issued with the report's address in the accept cycle
      check(mem_req && mem_addr == a, "R1", "mem_req/addr", longint'(mem_addr), longint'(a));
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (timed) begin
      check(!in_ready, "R1", "in_ready after accept", in_ready, 0);
      cyc = 1;
      while (!in_ready && cyc < 40) begin @(negedge clk); cyc++; end
      // R8
      check(cyc <= 20, "R8", "cycles to finish", cyc, 20);
    end
  endtask

  // output monitor, R7 stability and order
  initial begin
    logic pend = 1'b0;
    logic [AW-1:0] ploc; logic pbit; logic [1:0] pkind;
    forever begin
      @(negedge clk);
      if (pend)
        check(out_valid && {out_frame, out_slot} == ploc && out_bit == pbit && out_kind == pkind,
              "R7", "stalled entry held", longint'({out_frame, out_slot}), longint'(ploc));
      case (ready_mode)
        0: out_ready = 1'b1;
        1: out_ready = ($urandom % 3) != 0;
        default: out_ready = ($urandom % 4) == 0;
      endcase
      #1;
      pend = out_valid && !out_ready;
      ploc = {out_frame, out_slot}; pbit = out_bit; pkind = out_kind;
      if (out_valid && out_ready) begin
        if (q_rd >= q_wr) check(0, "R7", "unexpected entry", 1, 0);
        else begin
          check({out_frame, out_slot} == q_loc[q_rd], "R7", "entry location",
                longint'({out_frame, out_slot}), longint'(q_loc[q_rd]));
          check(out_bit == q_bit[q_rd], "R2", "key bit", out_bit, q_bit[q_rd]);
          check(out_kind == q_kind[q_rd], "R6/R5", "kind", out_kind, q_kind[q_rd]);
          q_rd++;
        end
      end
    end
  end

  task automatic drain();
    int g = 0;
    while ((q_rd < q_wr || !in_ready) && g < 2000) begin @(negedge clk); g++; end
    repeat (LAT + 4) @(negedge clk);
  endtask

  task automatic check_counts(input string tag);
    check(cnt_signal == CW'(e_sig), "R6", {tag, " cnt_signal"}, cnt_signal, e_sig);
    check(cnt_decoy == CW'(e_dec), "R5", {tag, " cnt_decoy"}, cnt_decoy, e_dec);
    check(cnt_vacuum == CW'(e_vac), "R4", {tag, " cnt_vacuum"}, cnt_vacuum, e_vac);
    check(cnt_mismatch == CW'(e_mis), "R3", {tag, " cnt_mismatch"}, cnt_mismatch, e_mis);
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < DEPTH; i++) begin
      int r;
      r = $urandom % 8;
      store[i][3:2] = (r < 6) ? 2'd0 : (r == 6 ? 2'd1 : 2'd2);
      store[i][1:0] = 2'($urandom % 4);
    end
    for (int i = 0; i < 16; i++) store[i] = 4'(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9
    check(in_ready == 1'b1, "R9", "in_ready at reset", in_ready, 1);
    check(out_valid == 1'b0, "R9", "out_valid at reset", out_valid, 0);
    check_counts("R9 reset");

    // directed: every symbol code with both bases (R2, R3, R4, R5)
    ready_mode = 0;
    for (int i = 0; i < 16; i++) begin
      send(AW'(i), 1'b0, 1'b1);
      send(AW'(i), 1'b1, 1'b1);
    end
    drain();
    check_counts("directed");
    check(e_vac == 8 && e_mis == 16, "R4", "directed bench tally", e_vac, 8);

    // random with output stalls (R6, R7)
    for (int n = 0; n < NRAND; n++) begin
      if (n % 300 == 0) ready_mode = (n / 300) % 3;
      send(AW'($urandom % DEPTH), 1'($urandom % 2), 1'b0);
    end
    drain();
    check_counts("random");

    // reset mid-run restarts counters and sample phase (R9)
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    e_sig = 0; e_dec = 0; e_vac = 0; e_mis = 0;
    @(negedge clk);
    check_counts("R9 re-reset");
    ready_mode = 0;
    for (int n = 0; n < 60; n++) send(AW'($urandom % DEPTH), 1'($urandom % 2), 1'b0);
    drain();
    check_counts("after re-reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule